// File: doc/BRIEF.md
# Interrupt Mask Flag and Entry Arbiter

This block holds the two interrupt-mask flags of a small 8-bit processor's condition code register and decides which interrupt the core takes next. The X flag gates one external, active-low, level-sensitive interrupt pin. The I flag gates a vector of ordinary maskable requests. Two more sources are synchronous to the instruction stream: an illegal-opcode trap and a software-interrupt instruction. Both bypass the mask flags completely.

The core pulses `instr_boundary` at every instruction boundary. The block captures the winning request in a selection register. That register shows the request on `pend_valid` / `pend_kind` / `pend_idx` together with the program-counter value to push. The selection acts as a one-deep valid/ready slot, with `entry_stb` as the ready side:
- A held selection stays frozen until the core pulses `entry_stb`. This pulse means the condition code register has been stacked.
- An `entry_stb` with no valid selection is ignored.

On entry, the block reports the kind taken for that cycle and updates the flags. Software writes and return-from-interrupt restores also reach the flags through plain control pins. The X flag is special: software can clear it but can never set it. After software first clears X, the pin therefore becomes truly non-maskable.

Top module: `nmi_mask_ctrl`

## Requirements
- R1: While reset is active, and on the cycle after it is released, `x_mask` and `i_mask` are both 1, `pend_valid` is 0 and `take_kind` is 0 even if `entry_stb` is high.
- R2: A software write (`ccr_wr_en`) loads `i_mask` from `ccr_wr_i`. It clears `x_mask` when `ccr_wr_x` is 0 and never sets it: once `x_mask` is 0, a write with `ccr_wr_x`=1 leaves it 0.
- R3: Taking a maskable interrupt sets `i_mask` on the edge that ends the `entry_stb` cycle and leaves `x_mask` unchanged.
- R4: Taking the external pin interrupt sets both `x_mask` and `i_mask` on the edge that ends the `entry_stb` cycle.
- R5: A restore (`rti_en`) loads `x_mask` from `rti_x` and `i_mask` from `rti_i`. Apart from reset and pin entry, this is the only way `x_mask` can become 1.
- R6: The pin (`ext_nmi_n`, active low) passes through two flip-flops before it is sampled at a boundary. A low level held for two clock edges is seen at the next boundary. The pin is taken only while `x_mask` is 0.
- R7: The priority at a boundary is illegal-opcode trap, then software interrupt, then the external pin, then maskable requests. Among maskable requests the lowest index wins, and they compete only while `i_mask` is 0.
- R8: The illegal-opcode trap and the software interrupt are taken whatever the values of `x_mask` and `i_mask`. Taking either sets `i_mask` and leaves `x_mask` unchanged.
- R9: `push_pc` is `cur_pc` (the address of the first byte of the current opcode) for an illegal-opcode trap and `next_pc` for every other kind.
- R10: `pend_kind` and `take_kind` use the one-hot code bit0 = maskable, bit1 = pin, bit2 = software interrupt, bit3 = illegal opcode. `take_kind` equals the selection only in a cycle where `entry_stb` is high and `pend_valid` is 1, and is 0 otherwise. `pend_valid` drops on the edge that ends that cycle.
- R11: While a selection is held, further boundaries are ignored. `pend_kind`, `pend_idx` and `push_pc` stay unchanged until entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_nmi_n | input | 1 | External interrupt pin, active low, level |
| illop_req | input | 1 | Illegal-opcode detected at this boundary |
| swi_req | input | 1 | Software-interrupt instruction at this boundary |
| mask_req | input | NUM_MREQ | Maskable request lines, index 0 highest |
| instr_boundary | input | 1 | Instruction boundary strobe |
| cur_pc | input | PC_W | Address of first byte of current opcode |
| next_pc | input | PC_W | Address of the following instruction |
| ccr_wr_en | input | 1 | Software write of the mask flags |
| ccr_wr_x | input | 1 | Written X value |
| ccr_wr_i | input | 1 | Written I value |
| rti_en | input | 1 | Return-from-interrupt restore |
| rti_x | input | 1 | X value from the pulled CCR byte |
| rti_i | input | 1 | I value from the pulled CCR byte |
| entry_stb | input | 1 | Entry strobe, CCR already stacked |
| x_mask | output | 1 | Current X flag |
| i_mask | output | 1 | Current I flag |
| pend_valid | output | 1 | A selection is held |
| pend_kind | output | 4 | One-hot kind of the held selection |
| pend_idx | output | IDX_W | Index of the held maskable request |
| push_pc | output | PC_W | Program counter value to stack |
| take_kind | output | 4 | One-hot kind taken, valid with entry_stb |

## Verification
The results arrive at different times:
- `take_kind` is combinational and appears in the same cycle as `entry_stb`.
- The selection outputs change one edge after a boundary.
- The flags change one edge after a write, a restore or an entry.
- A change on the pin needs two edges before a boundary can see it.

The bench drives every input on the falling edge and reads outputs on a falling edge. For `take_kind` it reads shortly after driving the strobe; for everything else it reads one full cycle after the event. It then sweeps every reachable flag state, pin level, trap, software-interrupt and all sixteen maskable patterns, and compares the arbitration and flag results with values it computes from the priority rules.

// File: rtl/nmi_ctrl_pkg.sv
package nmi_ctrl_pkg;
  // One-hot kind code; bit positions are decoded by the core
  typedef enum logic [3:0] {
    KIND_NONE = 4'b0000,
    KIND_MASK = 4'b0001,
    KIND_PIN  = 4'b0010,
    KIND_SWI  = 4'b0100,
    KIND_ILL  = 4'b1000
  } kind_e;

  localparam int KIND_W = 4;
endpackage

// File: rtl/nmi_pin_sync.sv
module nmi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic req_lvl
);
  logic [STAGES-1:0] chain_q;

  // first stage samples the raw pin; idle level is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b1;
    else        chain_q[0] <= pin_n;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= 1'b1;
      else        chain_q[s] <= chain_q[s-1];
    end
  end

  assign req_lvl = ~chain_q[STAGES-1];

  // R6
  sync_idle_after_reset_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> !req_lvl);
endmodule

// File: rtl/ccr_mask_regs.sv
module ccr_mask_regs
  import nmi_ctrl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  take,
  input  kind_e take_kind,
  input  logic  rti_en,
  input  logic  rti_x,
  input  logic  rti_i,
  input  logic  wr_en,
  input  logic  wr_x,
  input  logic  wr_i,
  output logic  x_q,
  output logic  i_q
);
  // Order: entry, then restore, then software write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= 1'b1;
      i_q <= 1'b1;
    end else if (take) begin
      i_q <= 1'b1;
      if (take_kind == KIND_PIN) x_q <= 1'b1;
    end else if (rti_en) begin
      x_q <= rti_x;
      i_q <= rti_i;
    end else if (wr_en) begin
      x_q <= x_q & wr_x;
      i_q <= wr_i;
    end
  end

  // R2
  x_no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!x_q && !rti_en && !(take && take_kind == KIND_PIN)) |=> !x_q);

  // R3
  mask_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_kind == KIND_MASK) |=> (i_q && x_q == $past(x_q)));

  // R4
  pin_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_kind == KIND_PIN) |=> (i_q && x_q));

  // R5
  restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rti_en && !take) |=> (x_q == $past(rti_x) && i_q == $past(rti_i)));

  // R8
  sync_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (take_kind == KIND_SWI || take_kind == KIND_ILL))
      |=> (i_q && x_q == $past(x_q)));
endmodule

// File: rtl/intr_select.sv
module intr_select
  import nmi_ctrl_pkg::*;
#(
  parameter int NUM_MREQ = 4,
  parameter int PC_W     = 16,
  localparam int IDX_W   = (NUM_MREQ > 1) ? $clog2(NUM_MREQ) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                boundary,
  input  logic                entry_stb,
  input  logic                x_m,
  input  logic                i_m,
  input  logic                pin_lvl,
  input  logic                ill,
  input  logic                swi,
  input  logic [NUM_MREQ-1:0] mreq,
  input  logic [PC_W-1:0]     cur_pc,
  input  logic [PC_W-1:0]     nxt_pc,
  output logic                sel_v,
  output kind_e               sel_kind,
  output logic [IDX_W-1:0]    sel_idx,
  output logic [PC_W-1:0]     sel_pc,
  output logic                take,
  output kind_e               take_kind
);
  logic [NUM_MREQ-1:0] vis;
  logic                m_hit;
  logic [IDX_W-1:0]    m_idx;
  kind_e               cand;
  logic                latch;

  assign vis = i_m ? '0 : mreq;

  // fixed priority, index 0 first
  always_comb begin
    m_hit = 1'b0;
    m_idx = '0;
    for (int k = NUM_MREQ - 1; k >= 0; k--) begin
      if (vis[k]) begin
        m_hit = 1'b1;
        m_idx = IDX_W'(k);
      end
    end
  end

  always_comb begin
    if (ill)                 cand = KIND_ILL;
    else if (swi)            cand = KIND_SWI;
    else if (pin_lvl && !x_m) cand = KIND_PIN;
    else if (m_hit)          cand = KIND_MASK;
    else                     cand = KIND_NONE;
  end

  assign latch     = boundary && !sel_v && (cand != KIND_NONE);
  assign take      = entry_stb && sel_v;
  assign take_kind = take ? sel_kind : KIND_NONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_v    <= 1'b0;
      sel_kind <= KIND_NONE;
      sel_idx  <= '0;
      sel_pc   <= '0;
    end else if (take) begin
      sel_v    <= 1'b0;
      sel_kind <= KIND_NONE;
    end else if (latch) begin
      sel_v    <= 1'b1;
      sel_kind <= cand;
      sel_idx  <= m_idx;
      sel_pc   <= ill ? cur_pc : nxt_pc;
    end
  end

  // R10
  kind_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_kind) && (sel_v == (sel_kind != KIND_NONE)));

  // R6
  pin_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch |=> (sel_kind != KIND_PIN || !$past(x_m)));

  // R7
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch |=> (sel_kind != KIND_MASK || !$past(i_m)));

  // R9
  trap_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && ill) |=> (sel_pc == $past(cur_pc)));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_v && !entry_stb) |=> (sel_v && $stable(sel_kind) && $stable(sel_pc)));
endmodule

// File: rtl/nmi_mask_ctrl.sv
module nmi_mask_ctrl
  import nmi_ctrl_pkg::*;
#(
  parameter int NUM_MREQ    = 4,
  parameter int PC_W        = 16,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = (NUM_MREQ > 1) ? $clog2(NUM_MREQ) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ext_nmi_n,
  input  logic                illop_req,
  input  logic                swi_req,
  input  logic [NUM_MREQ-1:0] mask_req,
  input  logic                instr_boundary,
  input  logic [PC_W-1:0]     cur_pc,
  input  logic [PC_W-1:0]     next_pc,
  input  logic                ccr_wr_en,
  input  logic                ccr_wr_x,
  input  logic                ccr_wr_i,
  input  logic                rti_en,
  input  logic                rti_x,
  input  logic                rti_i,
  input  logic                entry_stb,
  output logic                x_mask,
  output logic                i_mask,
  output logic                pend_valid,
  output logic [3:0]          pend_kind,
  output logic [IDX_W-1:0]    pend_idx,
  output logic [PC_W-1:0]     push_pc,
  output logic [3:0]          take_kind
);
  logic  pin_lvl;
  logic  take;
  kind_e sel_kind;
  kind_e tk;

  nmi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_n   (ext_nmi_n),
    .req_lvl (pin_lvl)
  );

  intr_select #(.NUM_MREQ(NUM_MREQ), .PC_W(PC_W)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .boundary  (instr_boundary),
    .entry_stb (entry_stb),
    .x_m       (x_mask),
    .i_m       (i_mask),
    .pin_lvl   (pin_lvl),
    .ill       (illop_req),
    .swi       (swi_req),
    .mreq      (mask_req),
    .cur_pc    (cur_pc),
    .nxt_pc    (next_pc),
    .sel_v     (pend_valid),
    .sel_kind  (sel_kind),
    .sel_idx   (pend_idx),
    .sel_pc    (push_pc),
    .take      (take),
    .take_kind (tk)
  );

  ccr_mask_regs u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .take_kind (tk),
    .rti_en    (rti_en),
    .rti_x     (rti_x),
    .rti_i     (rti_i),
    .wr_en     (ccr_wr_en),
    .wr_x      (ccr_wr_x),
    .wr_i      (ccr_wr_i),
    .x_q       (x_mask),
    .i_q       (i_mask)
  );

  assign pend_kind = sel_kind;
  assign take_kind = tk;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (x_mask && i_mask && !pend_valid));
endmodule

// File: tb/sim_nmi_mask_ctrl.sv
module sim_nmi_mask_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_nmi_n = 1'b1, illop_req = 1'b0, swi_req = 1'b0;
  logic [N-1:0] mask_req = '0;
  logic instr_boundary = 1'b0;
  logic [15:0] cur_pc = '0, next_pc = '0;
  logic ccr_wr_en = 1'b0, ccr_wr_x = 1'b0, ccr_wr_i = 1'b0;
  logic rti_en = 1'b0, rti_x = 1'b0, rti_i = 1'b0;
  logic entry_stb = 1'b0;
  logic x_mask, i_mask, pend_valid;
  logic [3:0] pend_kind, take_kind;
  logic [1:0] pend_idx;
  logic [15:0] push_pc;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nmi_mask_ctrl #(.NUM_MREQ(N), .PC_W(16), .SYNC_STAGES(2)) u0 (
    .clk, .rst_n, .ext_nmi_n, .illop_req, .swi_req, .mask_req,
    .instr_boundary, .cur_pc, .next_pc, .ccr_wr_en, .ccr_wr_x, .ccr_wr_i,
    .rti_en, .rti_x, .rti_i, .entry_stb, .x_mask, .i_mask, .pend_valid,
    .pend_kind, .pend_idx, .push_pc, .take_kind
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_fall(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wait_fall(2);
    rst_n = 1'b1;
    wait_fall(1);
  endtask

  task automatic sw_write(input bit wx, input bit wi);
    ccr_wr_en = 1'b1; ccr_wr_x = wx; ccr_wr_i = wi;
    wait_fall(1);
    ccr_wr_en = 1'b0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
    finish_up();
  end

  initial begin
    // R1 reset state
    wait_fall(1);
    chk(x_mask && i_mask, "R1", {x_mask, i_mask}, 3);
    rst_n = 1'b1;
    wait_fall(1);
    entry_stb = 1'b1;
    #1;
    chk(x_mask && i_mask && !pend_valid, "R1", {x_mask, i_mask, pend_valid}, 6);
    chk(take_kind == 4'b0000, "R1", take_kind, 0);
    wait_fall(1);
    entry_stb = 1'b0;
    chk(x_mask && i_mask, "R1", {x_mask, i_mask}, 3);

    // R2 write can clear X, never set it
    sw_write(1'b0, 1'b0);
    chk(!x_mask && !i_mask, "R2", {x_mask, i_mask}, 0);
    sw_write(1'b1, 1'b1);
    chk(!x_mask && i_mask, "R2", {x_mask, i_mask}, 1);

    // R5 restore sets X from the pulled byte
    rti_en = 1'b1; rti_x = 1'b1; rti_i = 1'b0;
    wait_fall(1);
    rti_en = 1'b0;
    chk(x_mask && !i_mask, "R5", {x_mask, i_mask}, 2);
    rti_en = 1'b1; rti_x = 1'b0; rti_i = 1'b1;
    wait_fall(1);
    rti_en = 1'b0;
    chk(!x_mask && i_mask, "R5", {x_mask, i_mask}, 1);

    // R6 pin needs two edges through the synchronizer
    ext_nmi_n = 1'b0;
    wait_fall(1);
    instr_boundary = 1'b1;
    wait_fall(1);
    instr_boundary = 1'b0;
    chk(!pend_valid, "R6", pend_valid, 0);
    wait_fall(1);
    instr_boundary = 1'b1;
    wait_fall(1);
    instr_boundary = 1'b0;
    chk(pend_valid && pend_kind == 4'b0010, "R6", pend_kind, 2);
    ext_nmi_n = 1'b1;

    // R11 held selection ignores a later boundary
    illop_req = 1'b1; cur_pc = 16'h0BAD; instr_boundary = 1'b1;
    wait_fall(1);
    illop_req = 1'b0; instr_boundary = 1'b0;
    chk(pend_kind == 4'b0010, "R11", pend_kind, 2);
    entry_stb = 1'b1;
    wait_fall(1);
    entry_stb = 1'b0;
    chk(!pend_valid, "R10", pend_valid, 0);

    // Sweep: flag states x pin x trap x swi x all maskable patterns
    for (int xs = 0; xs < 2; xs++)
      for (int is = 0; is < 2; is++)
        for (int pn = 0; pn < 2; pn++)
          for (int il = 0; il < 2; il++)
            for (int sw = 0; sw < 2; sw++)
              for (int m = 0; m < 16; m++) begin
                int ek, eidx;
                logic [15:0] cp, np, epc;
                do_reset();
                sw_write(xs[0], is[0]);
                ext_nmi_n = ~pn[0];
                wait_fall(3);
                cp = 16'h4000 + 16'(m * 8 + sw * 4 + il * 2 + pn);
                np = cp + 16'd3;
                eidx = 0;
                for (int b = 3; b >= 0; b--) if (m[b]) eidx = b;
                if (il == 1)                         ek = 8;
                else if (sw == 1)                    ek = 4;
                else if (pn == 1 && xs == 0)         ek = 2;
                else if (m != 0 && is == 0)          ek = 1;
                else                                 ek = 0;
                epc = (il == 1) ? cp : np;
                illop_req = il[0]; swi_req = sw[0]; mask_req = m[3:0];
                cur_pc = cp; next_pc = np; instr_boundary = 1'b1;
                wait_fall(1);
                illop_req = 1'b0; swi_req = 1'b0; mask_req = '0;
                instr_boundary = 1'b0;
                // R7 priority, R8 masks ignored by traps
                chk(pend_valid == (ek != 0), "R7", pend_valid, ek != 0);
                chk(int'(pend_kind) == ek, (ek >= 4) ? "R8" : "R7", pend_kind, ek);
                if (ek == 1) chk(int'(pend_idx) == eidx, "R7", pend_idx, eidx);
                if (ek != 0) begin
                  chk(push_pc == epc, "R9", push_pc, epc);
                  entry_stb = 1'b1;
                  #1;
                  chk(int'(take_kind) == ek, "R10", take_kind, ek);
                  wait_fall(1);
                  entry_stb = 1'b0;
                  chk(!pend_valid && take_kind == 4'b0000, "R10", pend_valid, 0);
                  if (ek == 2)
                    chk(x_mask && i_mask, "R4", {x_mask, i_mask}, 3);
                  else if (ek == 1)
                    chk(x_mask == xs[0] && i_mask, "R3", {x_mask, i_mask}, {xs[0], 1'b1});
                  else
                    chk(x_mask == xs[0] && i_mask, "R8", {x_mask, i_mask}, {xs[0], 1'b1});
                end
                ext_nmi_n = 1'b1;
              end

    finish_up();
  end
endmodule